// File: doc/BRIEF.md
# Exception Priority Arbiter

This block sits next to a small processor core and decides which pending exception the core should start, and when. It watches five request sources: an external reset pin, a watchdog overflow pulse, a level-sensitive interrupt line, a direct-transition request raised by a sleep instruction, and a trap request raised by a trap instruction. Two core status strobes mark the points where a decision may be made: one for instruction completion and one for completion of exception handling.

A reset, whether from a rising edge on the synchronized pin or from a watchdog pulse, starts at once. It also discards every other held request and abandons any handling sequence already under way. The other classes wait for a boundary. At each boundary the arbiter starts at most one exception, in the fixed order interrupt, then direct transition, then trap. Anything still waiting is taken at the next boundary, which is the end of the handling just started. The arbiter skips interrupt detection for one boundary in two cases: after an instruction that wrote the condition/control register, and after reset handling finishes.

Top module: `exc_prio_arbiter`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after it is released, `start_o` and `busy_o` are 0.
- R2: A rising edge on `rst_pin_i` passes through `SYNC_STAGES` synchronizer flops and an edge detector. `start_o` pulses with `code_o` = 2'b00 (reset) exactly `SYNC_STAGES`+1 clock edges after the pin is first sampled high. A pin that stays high starts nothing more.
- R3: A cycle with `wdt_ovf_i` high gives a reset start (`code_o` = 2'b00) on the next edge, whatever the state of the arbiter.
- R4: A reset start discards any held direct-transition or trap request, including one that arrives in the same cycle, and replaces any handling already in progress.
- R5: An interrupt starts only at a boundary. A boundary is `insn_done_i` while idle, or `exc_done_i` while busy. `insn_done_i` while busy and `exc_done_i` while idle have no effect.
- R6: When several requests are eligible at one boundary, the arbiter starts interrupt (code 2'b01) over direct transition (2'b10) over trap (2'b11).
- R7: While busy, the arbiter starts nothing except a reset until `exc_done_i`. Requests that are still held are then started one per boundary.
- R8: At an `insn_done_i` boundary with `ccr_write_i` high, the interrupt line is ignored, but a held direct-transition or trap request may still start.
- R9: At the `exc_done_i` that ends reset handling, the interrupt line is ignored.
- R10: The interrupt line is not latched. If it falls before a boundary, no interrupt starts.
- R11: A direct-transition or trap pulse is held until it is started and is cleared by that start, so it runs exactly once.
- R12: `start_o` is high for one cycle per start, and `busy_o` is high from that start until an `exc_done_i` that starts nothing further.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| rst_pin_i | input | 1 | External reset pin, asynchronous; a rising edge requests reset handling |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse, synchronous |
| irq_i | input | 1 | Interrupt request level |
| dtr_req_i | input | 1 | Direct-transition request pulse from a sleep instruction |
| trap_req_i | input | 1 | Trap request pulse from a trap instruction |
| insn_done_i | input | 1 | Core finished an instruction this cycle |
| ccr_write_i | input | 1 | The instruction finishing this cycle wrote the condition/control register |
| exc_done_i | input | 1 | Core finished the exception handling in progress |
| start_o | output | 1 | One-cycle start command |
| code_o | output | 2 | Exception class of the start: 00 reset, 01 interrupt, 10 direct transition, 11 trap |
| busy_o | output | 1 | Exception handling in progress |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 rather than the default 2. This shows whether the reset-pin latency follows the parameter and not a fixed two-flop value, and it widens the window in which a pin edge overlaps other traffic. The watchdog and reset-pin rates in the random phase are low enough that full interrupt, direct-transition and trap sequences run between resets. They are still high enough that resets often land in the middle of a sequence, while requests are being held.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;

    typedef enum logic [1:0] {
        EXC_RESET = 2'b00,
        EXC_IRQ   = 2'b01,
        EXC_DTR   = 2'b10,
        EXC_TRAP  = 2'b11
    } exc_code_e;

    // Non-reset classes in picker slot order; slot k maps to code k+1
    localparam int unsigned PICK_N = 3;
    // Classes that are held until started: direct transition, trap
    localparam int unsigned HOLD_N = 2;

    typedef struct packed {
        logic      start;
        exc_code_e code;
        logic      busy;
    } seq_state_t;

endpackage

// File: rtl/exc_pin_edge.sv
module exc_pin_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], pin_i};
        st_d.last = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise_o = st_q.sync[STAGES-1] & ~st_q.last;

endmodule

// File: rtl/exc_req_hold.sv
module exc_req_hold #(
    parameter int unsigned N = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         flush_i,
    output logic [N-1:0] eff_o
);
    logic [N-1:0] pend_d, pend_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        assign pend_d[g] = flush_i ? 1'b0 : ((pend_q[g] | set_i[g]) & ~clr_i[g]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q <= '0;
        else         pend_q <= pend_d;
    end

    // Held requests plus ones arriving this cycle
    assign eff_o = pend_q | set_i;

endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
    parameter int unsigned N  = 3,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  grant_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    // Lowest slot wins
    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                idx_o      = IW'(i);
            end
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/exc_prio_arbiter.sv
module exc_prio_arbiter
    import exc_arb_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       rst_pin_i,
    input  logic       wdt_ovf_i,
    input  logic       irq_i,
    input  logic       dtr_req_i,
    input  logic       trap_req_i,
    input  logic       insn_done_i,
    input  logic       ccr_write_i,
    input  logic       exc_done_i,
    output logic       start_o,
    output logic [1:0] code_o,
    output logic       busy_o
);
    localparam int unsigned IW = $clog2(PICK_N);

    seq_state_t          seq_d, seq_q;
    logic                pin_rise;
    logic                rst_evt;
    logic [HOLD_N-1:0]   held_eff;
    logic [HOLD_N-1:0]   held_clr;
    logic [PICK_N-1:0]   pick_req;
    logic [PICK_N-1:0]   pick_gnt;
    logic [IW-1:0]       pick_idx;
    logic                pick_any;
    logic                boundary;
    logic                irq_open;
    logic                take;

    exc_pin_edge #(.STAGES(SYNC_STAGES)) i_pin_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (rst_pin_i),
        .rise_o (pin_rise)
    );

    exc_req_hold #(.N(HOLD_N)) i_req_hold (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   ({trap_req_i, dtr_req_i}),
        .clr_i   (held_clr),
        .flush_i (rst_evt),
        .eff_o   (held_eff)
    );

    exc_prio_sel #(.N(PICK_N)) i_prio_sel (
        .req_i   (pick_req),
        .grant_o (pick_gnt),
        .idx_o   (pick_idx),
        .any_o   (pick_any)
    );

    assign rst_evt  = pin_rise | wdt_ovf_i;
    assign boundary = seq_q.busy ? exc_done_i : insn_done_i;
    // Interrupt detection skipped after reset handling or a control-register write
    assign irq_open = seq_q.busy ? (seq_q.code != EXC_RESET) : ~ccr_write_i;
    assign pick_req = {held_eff, irq_i & irq_open};
    assign take     = boundary & pick_any & ~rst_evt;
    assign held_clr = take ? pick_gnt[PICK_N-1:1] : '0;

    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        if (rst_evt) begin
            seq_d.start = 1'b1;
            seq_d.code  = EXC_RESET;
            seq_d.busy  = 1'b1;
        end else if (take) begin
            seq_d.start = 1'b1;
            seq_d.code  = exc_code_e'(pick_idx + 2'd1);
            seq_d.busy  = 1'b1;
        end else if (seq_q.busy && exc_done_i) begin
            seq_d.busy  = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '0;
        else         seq_q <= seq_d;
    end

    assign start_o = seq_q.start;
    assign code_o  = seq_q.code;
    assign busy_o  = seq_q.busy;

endmodule

// File: rtl/exc_prio_arbiter_chk.sv
module exc_prio_arbiter_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       wdt_ovf_i,
    input logic       insn_done_i,
    input logic       ccr_write_i,
    input logic       exc_done_i,
    input logic       start_o,
    input logic [1:0] code_o,
    input logic       busy_o
);
    assert_wdt_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdt_ovf_i |=> (start_o && code_o == 2'b00));

    assert_irq_boundary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!insn_done_i && !exc_done_i) |=> !(start_o && code_o == 2'b01));

    assert_hold_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !exc_done_i) |=> (!start_o || code_o == 2'b00));

    assert_ccr_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insn_done_i && ccr_write_i && !busy_o) |=> !(start_o && code_o == 2'b01));

    assert_start_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |-> busy_o);

endmodule

bind exc_prio_arbiter exc_prio_arbiter_chk i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wdt_ovf_i   (wdt_ovf_i),
    .insn_done_i (insn_done_i),
    .ccr_write_i (ccr_write_i),
    .exc_done_i  (exc_done_i),
    .start_o     (start_o),
    .code_o      (code_o),
    .busy_o      (busy_o)
);

// File: tb/test_exc_prio_arbiter.sv
module test_exc_prio_arbiter;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int unsigned SYNC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin = 1'b0, wdt = 1'b0, irq = 1'b0, dtr = 1'b0, trap = 1'b0;
    logic ind = 1'b0, ccr = 1'b0, done = 1'b0;
    logic start;
    logic [1:0] code;
    logic busy;

    int checks = 0;
    int failures = 0;
    string tag = "R1";

    // reference model state
    logic [SYNC-1:0] m_sync = '0;
    logic m_last = 1'b0, m_start = 1'b0, m_busy = 1'b0, m_pd = 1'b0, m_pt = 1'b0;
    logic [1:0] m_code = 2'b00;

    always #2.5 clk = ~clk;

    exc_prio_arbiter #(.SYNC_STAGES(SYNC)) i_exc_prio_arbiter (
        .clk_i(clk), .rst_ni(rst_n), .rst_pin_i(pin), .wdt_ovf_i(wdt), .irq_i(irq),
        .dtr_req_i(dtr), .trap_req_i(trap), .insn_done_i(ind), .ccr_write_i(ccr),
        .exc_done_i(done), .start_o(start), .code_o(code), .busy_o(busy)
    );

    task automatic chk(input logic ok, input string t, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
        end
    endtask

    // Expected class at a boundary: 0 none, else code 1..3
    function automatic int pick(input logic i, input logic d, input logic t);
        if (i) return 1;
        if (d) return 2;
        if (t) return 3;
        return 0;
    endfunction

    task automatic cyc();
        logic [SYNC-1:0] n_sync;
        logic n_last, n_start, n_busy, n_pd, n_pt, evt, bnd, iok, dp, tp;
        logic [1:0] n_code;
        int w;
        n_sync = {m_sync[SYNC-2:0], pin};
        n_last = m_sync[SYNC-1];
        evt = (m_sync[SYNC-1] & ~m_last) | wdt;
        dp = m_pd | dtr;
        tp = m_pt | trap;
        n_start = 1'b0; n_code = m_code; n_busy = m_busy; n_pd = dp; n_pt = tp;
        if (evt) begin
            n_start = 1'b1; n_code = 2'b00; n_busy = 1'b1; n_pd = 1'b0; n_pt = 1'b0;
        end else begin
            bnd = m_busy ? done : ind;
            iok = irq & (m_busy ? (m_code != 2'b00) : ~ccr);
            w = pick(iok, dp, tp);
            if (bnd && w != 0) begin
                n_start = 1'b1; n_code = 2'(w); n_busy = 1'b1;
                if (w == 2) n_pd = 1'b0;
                if (w == 3) n_pt = 1'b0;
            end else if (m_busy && done) begin
                n_busy = 1'b0;
            end
        end
        @(posedge clk);
        #1;
        m_sync = n_sync; m_last = n_last; m_start = n_start; m_code = n_code;
        m_busy = n_busy; m_pd = n_pd; m_pt = n_pt;
        chk(start === m_start, {tag, " start"}, int'(start), int'(m_start));
        chk(busy === m_busy, {tag, " busy"}, int'(busy), int'(m_busy));
        if (m_start) chk(code === m_code, {tag, " code"}, int'(code), int'(m_code));
    endtask

    task automatic drv(input logic i, input logic d, input logic t, input logic w,
                       input logic n, input logic c, input logic x);
        irq = i; dtr = d; trap = t; wdt = w; ind = n; ccr = c; done = x;
        cyc();
        dtr = 1'b0; trap = 1'b0; wdt = 1'b0; ind = 1'b0; ccr = 1'b0; done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        chk(start == 1'b0 && busy == 1'b0, "R1 in reset", int'({start, busy}), 0);
        rst_n = 1'b1;
        tag = "R1";
        drv(0, 0, 0, 0, 0, 0, 0);
        chk(start == 1'b0 && busy == 1'b0, "R1 after release", int'({start, busy}), 0);

        // R2: pin edge latency, then R9: irq ignored at end of reset handling
        tag = "R2";
        pin = 1'b1;
        for (int k = 1; k <= SYNC + 1; k++) begin
            drv(0, 0, 0, 0, 0, 0, 0);
            chk(start == (k == SYNC + 1), "R2 pin latency", int'(start), int'(k == SYNC + 1));
        end
        repeat (6) drv(0, 0, 0, 0, 0, 0, 0);
        chk(start == 1'b0, "R2 held pin no restart", int'(start), 0);
        tag = "R9";
        drv(1, 0, 0, 0, 0, 0, 1);
        chk(start == 1'b0 && busy == 1'b0, "R9 irq skipped after reset", int'({start, busy}), 0);
        tag = "R5";
        drv(1, 0, 0, 0, 1, 0, 0);
        chk(start && code == 2'b01, "R5 irq at boundary", int'(code), 1);
        drv(0, 0, 0, 0, 0, 0, 1);
        pin = 1'b0;

        // R5: interrupt level with no boundary; insn_done while busy ignored
        repeat (5) drv(1, 0, 0, 0, 0, 0, 0);
        chk(start == 1'b0, "R5 no boundary", int'(start), 0);
        drv(0, 0, 0, 0, 0, 0, 1);
        chk(start == 1'b0, "R5 done while idle ignored", int'(start), 0);

        // R6/R7: all three eligible at once, served in order
        tag = "R6";
        drv(0, 1, 1, 0, 0, 0, 0);
        drv(1, 0, 0, 0, 1, 0, 0);
        chk(start && code == 2'b01, "R6 irq first", int'(code), 1);
        tag = "R7";
        repeat (3) drv(1, 0, 0, 0, 1, 0, 0);
        chk(start == 1'b0 && busy, "R7 no start while busy", int'(start), 0);
        tag = "R6";
        drv(0, 0, 0, 0, 0, 0, 1);
        chk(start && code == 2'b10, "R6 dtr second", int'(code), 2);
        drv(0, 0, 0, 0, 0, 0, 1);
        chk(start && code == 2'b11, "R6 trap third", int'(code), 3);
        drv(0, 0, 0, 0, 0, 0, 1);
        chk(start == 1'b0 && busy == 1'b0, "R12 busy clears", int'(busy), 0);

        // R8: control-register write masks irq but lets trap through
        tag = "R8";
        drv(1, 0, 1, 0, 1, 1, 0);
        chk(start && code == 2'b11, "R8 trap despite masked irq", int'(code), 3);
        drv(1, 0, 0, 0, 0, 0, 1);
        chk(start && code == 2'b01, "R8 irq at following boundary", int'(code), 1);
        drv(0, 0, 0, 0, 0, 0, 1);
        drv(1, 0, 0, 0, 1, 1, 0);
        chk(start == 1'b0, "R8 lone masked irq", int'(start), 0);

        // R10: interrupt drops before boundary
        tag = "R10";
        drv(1, 0, 0, 0, 0, 0, 0);
        drv(0, 0, 0, 0, 1, 0, 0);
        chk(start == 1'b0, "R10 irq not latched", int'(start), 0);

        // R3/R4: watchdog flushes held requests and aborts
        tag = "R4";
        drv(0, 1, 1, 0, 0, 0, 0);
        drv(0, 0, 0, 0, 1, 0, 0);
        chk(start && code == 2'b10, "R4 dtr starts", int'(code), 2);
        tag = "R3";
        drv(0, 1, 0, 1, 0, 0, 0);
        chk(start && code == 2'b00, "R3 watchdog reset", int'(code), 0);
        tag = "R4";
        drv(0, 0, 0, 0, 0, 0, 1);
        chk(start == 1'b0 && busy == 1'b0, "R4 flushed requests", int'({start, busy}), 0);
        drv(0, 0, 0, 0, 1, 0, 0);
        chk(start == 1'b0, "R4 nothing left", int'(start), 0);

        // R11: held pulse runs once
        tag = "R11";
        drv(0, 1, 0, 0, 0, 0, 0);
        repeat (4) drv(0, 0, 0, 0, 0, 0, 0);
        drv(0, 0, 0, 0, 1, 0, 0);
        chk(start && code == 2'b10, "R11 held dtr", int'(code), 2);
        tag = "R12";
        drv(0, 0, 0, 0, 0, 0, 0);
        chk(start == 1'b0 && busy, "R12 one-cycle pulse", int'(start), 0);
        tag = "R11";
        drv(0, 0, 0, 0, 0, 0, 1);
        drv(0, 0, 0, 0, 1, 0, 0);
        chk(start == 1'b0, "R11 runs once", int'(start), 0);

        // Random traffic checked against the model
        tag = "random R5-R12";
        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(199) == 0) pin = ~pin;
            if ($urandom_range(7) == 0) irq = ~irq;
            dtr  = ($urandom_range(19) == 0);
            trap = ($urandom_range(19) == 0);
            wdt  = ($urandom_range(299) == 0);
            ind  = ($urandom_range(2) == 0);
            ccr  = ($urandom_range(3) == 0);
            done = ($urandom_range(3) == 0);
            cyc();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule